// File: doc/BRIEF.md
# Root Port Link-Up Supervisor

This block decides whether one root port's link has come up after the port leaves reset. A one-cycle `start` pulse begins the check. The block then runs two timed polling phases, one after the other. The first phase waits for the data-link-up flag in a vendor status word. The second phase waits for the link-active flag in the link control/status word. Each phase is bounded by a count of one-millisecond ticks. The tick arrives on an input and is produced elsewhere on the chip.

When either phase runs out of ticks, the block drives the port reset for one tick period and then starts a new attempt. After a fixed number of failed attempts it reports failure. A success in phase two ends the run with `link_up`. The result flags hold their value until the next accepted `start`, so a power-up sequencer can read them at any later time.

Top module: `lnk_up_supervisor`

## Requirements
- R1: After reset, `port_rst`, `busy`, `link_up` and `link_fail` are all 0.
- R2: A `start` seen while the block is not busy clears `link_up` and `link_fail` and raises `busy` on the next clock. A `start` seen while busy has no effect on the run in progress or its timing.
- R3: In phase one the block reads bit 30 of `dl_word`. It reads it once in the cycle the phase begins and again on each `ms_tick`. A 1 on any read moves the block to phase two.
- R4: Phase one allows at most 200 ticks. On the 200th tick the bit is not read: the attempt times out and goes straight to the reset pulse, skipping phase two. A 1 read on the 199th tick still counts as success.
- R5: Phase two reads bit 29 of `ls_word` on its first cycle and on each tick, with its tick budget refilled to 200. A 1 sets `link_up` and drops `busy` on the next clock.
- R6: A phase-two run of 200 ticks without bit 29 ends the attempt with a reset pulse.
- R7: `port_rst` rises on the clock after a timeout and stays high until the next `ms_tick`. It falls on the clock that samples that tick, and a fresh attempt begins at phase one.
- R8: At most 3 attempts are made. The reset pulse that ends the third failed attempt is followed by `link_fail` = 1 and `busy` = 0.
- R9: `link_up` and `link_fail` are never both 1. Each keeps its value until the next accepted `start`.
- R10: Bits of `dl_word` other than bit 30 and bits of `ls_word` other than bit 29 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run a link check |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| dl_word | input | WORD_W | Vendor status word; bit 30 is data-link-up |
| ls_word | input | WORD_W | Link control/status word; bit 29 is link active |
| port_rst | output | 1 | Port reset control, high while a reset pulse is applied |
| busy | output | 1 | A check is in progress |
| link_up | output | 1 | Last check succeeded |
| link_fail | output | 1 | Last check used up all attempts |

## Verification
Every output is a register or a decode of the state register, so each result appears on the clock after the edge that samples its cause. `busy` follows an accepted `start` by one clock. A probe sees a status bit one clock after the phase begins. `link_up` rises one clock after the sampling edge or tick. `port_rst` rises one clock after the expiring tick and falls one clock after the next tick. The bench's behavioural model advances on the same rising edge as the design, and all four outputs are compared at the falling edge. The bench drives ticks one at a time, so each boundary case is placed on an exact tick number: the 199th tick succeeds and the 200th times out.

// File: rtl/lnk_sup_pkg.sv
package lnk_sup_pkg;

  typedef enum logic [2:0] {
    SUP_IDLE      = 3'd0,
    SUP_DL_PROBE  = 3'd1,
    SUP_DL_POLL   = 3'd2,
    SUP_LS_PROBE  = 3'd3,
    SUP_LS_POLL   = 3'd4,
    SUP_RST_PULSE = 3'd5,
    SUP_DONE      = 3'd6
  } sup_state_t;

endpackage

// File: rtl/lnk_tick_window.sv
// Tick budget for one polling phase: reload to LIMIT, count ticks down,
// flag the tick that exhausts the budget.
module lnk_tick_window #(
  parameter int unsigned LIMIT = 200,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          tick,
  output logic          expire,
  output logic [CW-1:0] remaining
);

  function automatic logic [CW-1:0] full_budget();
    return CW'(LIMIT);
  endfunction

  function automatic logic is_last(input logic [CW-1:0] c);
    return c == CW'(1);
  endfunction

  assign expire = tick && is_last(remaining);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining <= '0;
    end else if (load) begin
      remaining <= full_budget();
    end else if (tick && remaining != '0) begin
      remaining <= remaining - CW'(1);
    end
  end

  AST_WIN_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && remaining == '0)); // R4

endmodule

// File: rtl/lnk_try_tally.sv
// Counts finished attempts; flags the one that is the last allowed.
module lnk_try_tally #(
  parameter int unsigned MAX_TRIES = 3,
  localparam int unsigned TW = $clog2(MAX_TRIES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          bump,
  output logic          last,
  output logic [TW-1:0] done_cnt
);

  function automatic logic final_try(input logic [TW-1:0] c);
    return c == TW'(MAX_TRIES - 1);
  endfunction

  assign last = final_try(done_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_cnt <= '0;
    end else if (clr) begin
      done_cnt <= '0;
    end else if (bump) begin
      done_cnt <= done_cnt + TW'(1);
    end
  end

  AST_TRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bump |-> done_cnt < TW'(MAX_TRIES)); // R8

endmodule

// File: rtl/lnk_up_supervisor.sv
module lnk_up_supervisor
  import lnk_sup_pkg::*;
#(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned DL_BIT     = 30,
  parameter int unsigned LS_BIT     = 29,
  parameter int unsigned WAIT_TICKS = 200,
  parameter int unsigned MAX_TRIES  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ms_tick,
  input  logic [WORD_W-1:0] dl_word,
  input  logic [WORD_W-1:0] ls_word,
  output logic              port_rst,
  output logic              busy,
  output logic              link_up,
  output logic              link_fail
);

  localparam int unsigned CW = $clog2(WAIT_TICKS + 1);
  localparam int unsigned TW = $clog2(MAX_TRIES + 1);

  sup_state_t state, state_nx;

  logic dl_seen, ls_seen;
  logic in_poll, poll_tick, win_load, win_expire;
  logic pulse_end, start_ok, win_evt, fail_evt, try_last;
  logic [CW-1:0] win_left;
  logic [TW-1:0] tries_done;
  logic unused_bits;

  assign dl_seen     = dl_word[DL_BIT];
  assign ls_seen     = ls_word[LS_BIT];
  assign unused_bits = ^{dl_word, ls_word, win_left, tries_done};

  // Named internal events
  assign in_poll   = (state == SUP_DL_POLL) || (state == SUP_LS_POLL);
  assign poll_tick = in_poll && ms_tick;
  assign win_load  = (state == SUP_DL_PROBE) || (state == SUP_LS_PROBE);
  assign pulse_end = (state == SUP_RST_PULSE) && ms_tick;
  assign start_ok  = start && ((state == SUP_IDLE) || (state == SUP_DONE));
  assign win_evt   = ((state == SUP_LS_PROBE) && ls_seen) ||
                     ((state == SUP_LS_POLL) && ms_tick && !win_expire && ls_seen);
  assign fail_evt  = pulse_end && try_last;

  lnk_tick_window #(.LIMIT(WAIT_TICKS)) win_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (win_load),
    .tick      (poll_tick),
    .expire    (win_expire),
    .remaining (win_left)
  );

  lnk_try_tally #(.MAX_TRIES(MAX_TRIES)) tally_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start_ok),
    .bump     (pulse_end),
    .last     (try_last),
    .done_cnt (tries_done)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      SUP_IDLE, SUP_DONE: if (start_ok) state_nx = SUP_DL_PROBE;
      SUP_DL_PROBE:       state_nx = dl_seen ? SUP_LS_PROBE : SUP_DL_POLL;
      SUP_DL_POLL: begin
        if (win_expire)              state_nx = SUP_RST_PULSE;
        else if (ms_tick && dl_seen) state_nx = SUP_LS_PROBE;
      end
      SUP_LS_PROBE:       state_nx = ls_seen ? SUP_DONE : SUP_LS_POLL;
      SUP_LS_POLL: begin
        if (win_expire)              state_nx = SUP_RST_PULSE;
        else if (ms_tick && ls_seen) state_nx = SUP_DONE;
      end
      SUP_RST_PULSE: if (pulse_end) state_nx = try_last ? SUP_DONE : SUP_DL_PROBE;
      default:            state_nx = SUP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SUP_IDLE;
      link_up   <= 1'b0;
      link_fail <= 1'b0;
    end else begin
      state <= state_nx;
      if (start_ok) begin
        link_up   <= 1'b0;
        link_fail <= 1'b0;
      end else if (win_evt) begin
        link_up   <= 1'b1;
      end else if (fail_evt) begin
        link_fail <= 1'b1;
      end
    end
  end

  assign port_rst = (state == SUP_RST_PULSE);
  assign busy     = (state != SUP_IDLE) && (state != SUP_DONE);

  AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_up && link_fail)); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_ok && !win_evt && !fail_evt) |=> ($stable(link_up) && $stable(link_fail))); // R9
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (busy && !link_up && !link_fail)); // R2
  AST_EXPIRE_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    win_expire |=> port_rst); // R4
  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rst && !ms_tick) |=> port_rst); // R7
  AST_UP_NEEDS_LS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up) |-> $past(ls_word[LS_BIT])); // R5
  AST_FAIL_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_fail) |-> $past(port_rst)); // R8

endmodule

// File: tb/lnk_up_supervisor_tb.sv
`timescale 1ns/1ps
module lnk_up_supervisor_tb_top;

  localparam int TMO   = 200;
  localparam int TRIES = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ms_tick = 1'b0;
  logic [31:0] dl_word = '0;
  logic [31:0] ls_word = '0;
  logic port_rst, busy, link_up, link_fail;

  int checks = 0;
  int failures = 0;
  int cyc_count = 0;

  always #5 clk = ~clk;

  lnk_up_supervisor dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ms_tick(ms_tick),
    .dl_word(dl_word), .ls_word(ls_word),
    .port_rst(port_rst), .busy(busy), .link_up(link_up), .link_fail(link_fail)
  );

  // Behavioural reference: mode 0 idle, 1 dl first look, 2 dl waiting,
  // 3 ls first look, 4 ls waiting, 5 reset pulse, 6 finished
  int m_mode = 0, m_left = 0, m_att = 0;
  bit m_up = 0, m_fail = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_left = 0; m_att = 0; m_up = 0; m_fail = 0;
    end else begin
      if (m_mode == 0 || m_mode == 6) begin
        if (start) begin m_mode = 1; m_up = 0; m_fail = 0; m_att = 0; end
      end else if (m_mode == 1) begin
        m_left = TMO;
        m_mode = dl_word[30] ? 3 : 2;
      end else if (m_mode == 2) begin
        if (ms_tick) begin
          m_left = m_left - 1;
          if (m_left == 0) m_mode = 5;
          else if (dl_word[30]) m_mode = 3;
        end
      end else if (m_mode == 3) begin
        m_left = TMO;
        if (ls_word[29]) begin m_mode = 6; m_up = 1; end
        else m_mode = 4;
      end else if (m_mode == 4) begin
        if (ms_tick) begin
          m_left = m_left - 1;
          if (m_left == 0) m_mode = 5;
          else if (ls_word[29]) begin m_mode = 6; m_up = 1; end
        end
      end else if (m_mode == 5) begin
        if (ms_tick) begin
          m_att = m_att + 1;
          if (m_att == TRIES) begin m_mode = 6; m_fail = 1; end
          else m_mode = 1;
        end
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  // Cycle compare against the model
  always @(negedge clk) begin
    cyc_count++;
    if (rst_n) begin
      chk("R7 port_rst model", port_rst, m_mode == 5);
      chk("R2 busy model", busy, m_mode >= 1 && m_mode <= 5);
      chk("R5 link_up model", link_up, m_up);
      chk("R8 link_fail model", link_fail, m_fail);
    end
    if (cyc_count > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick1();
    @(negedge clk) ms_tick = 1'b1;
    @(negedge clk) ms_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick1();
  endtask

  task automatic kick();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  initial begin
    int rises;
    bit prev;
    cyc(3);
    // R1 reset values
    chk("R1 port_rst", port_rst, 1'b0);
    chk("R1 busy", busy, 1'b0);
    chk("R1 link_up", link_up, 1'b0);
    chk("R1 link_fail", link_fail, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    cyc(2);

    // R3 R5: both flags already present
    dl_word = 32'h4000_0000; ls_word = 32'h2000_0000;
    kick(); cyc(3);
    chk("R5 immediate link_up", link_up, 1'b1);
    chk("R3 busy done", busy, 1'b0);

    // R10: every other bit set, still waiting
    dl_word = ~32'h4000_0000; ls_word = ~32'h2000_0000;
    kick(); cyc(3); ticks(5);
    chk("R10 other dl bits ignored busy", busy, 1'b1);
    chk("R10 no link_up", link_up, 1'b0);
    dl_word = 32'h4000_0000; ls_word = ~32'h2000_0000;
    tick1(); cyc(3); ticks(5);
    chk("R10 other ls bits ignored busy", busy, 1'b1);
    ls_word = 32'h2000_0000;
    tick1(); cyc(1);
    chk("R5 link_up after ls tick", link_up, 1'b1);

    // R3 R4 boundary: bit seen on tick 199 succeeds
    dl_word = '0; ls_word = '0;
    kick(); cyc(2); ticks(198);
    dl_word = 32'h4000_0000;
    tick1(); cyc(3);
    chk("R4 tick 199 no pulse", port_rst, 1'b0);
    chk("R3 in phase two busy", busy, 1'b1);
    ls_word = 32'h2000_0000;
    tick1(); cyc(1);
    chk("R3 link_up after 199", link_up, 1'b1);

    // R4 R7: bit on tick 200 is not read, pulse follows
    dl_word = '0; ls_word = '0;
    kick(); cyc(2); ticks(199);
    chk("R4 before 200 no pulse", port_rst, 1'b0);
    dl_word = 32'h4000_0000; ls_word = 32'h2000_0000;
    tick1();
    chk("R4 timeout on tick 200", port_rst, 1'b1);
    chk("R4 phase two skipped", link_up, 1'b0);
    cyc(5);
    chk("R7 pulse held", port_rst, 1'b1);
    tick1();
    chk("R7 pulse ends on tick", port_rst, 1'b0);
    chk("R7 retry busy", busy, 1'b1);
    cyc(3);
    chk("R7 second attempt up", link_up, 1'b1);

    // R6: phase two timeout
    dl_word = 32'h4000_0000; ls_word = '0;
    kick(); cyc(3); ticks(199);
    chk("R6 no pulse at 199", port_rst, 1'b0);
    tick1();
    chk("R6 pulse after ls timeout", port_rst, 1'b1);
    ls_word = 32'h2000_0000;
    tick1(); cyc(3);
    chk("R6 retry succeeds", link_up, 1'b1);

    // R8: three failed attempts
    dl_word = '0; ls_word = '0;
    kick(); cyc(2);
    rises = 0; prev = 0;
    for (int g = 0; g < 1000 && busy; g++) begin
      tick1();
      if (port_rst && !prev) rises++;
      prev = port_rst;
    end
    chk("R8 three pulses", rises == 3, 1'b1);
    chk("R8 link_fail", link_fail, 1'b1);
    chk("R9 exclusive", link_up, 1'b0);
    chk("R8 not busy", busy, 1'b0);

    // R9 hold while idle
    dl_word = 32'hffff_ffff; ls_word = 32'hffff_ffff;
    ticks(10);
    chk("R9 link_fail held", link_fail, 1'b1);

    // R2: start during a run is ignored
    dl_word = '0; ls_word = '0;
    kick();
    chk("R2 start clears fail", link_fail, 1'b0);
    chk("R2 busy after start", busy, 1'b1);
    cyc(1); ticks(50);
    kick();
    ticks(149);
    chk("R2 no restart yet", port_rst, 1'b0);
    tick1();
    chk("R2 timer not restarted", port_rst, 1'b1);
    dl_word = 32'h4000_0000; ls_word = 32'h2000_0000;
    tick1(); cyc(3);
    chk("R2 run finishes up", link_up, 1'b1);
    ticks(5);
    chk("R9 link_up held", link_up, 1'b1);

    cyc(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule